// File: doc/BRIEF.md
# Burst Page-Mode DRAM Read Pipeline

This block is a cycle-accurate model of the read data path of a page-mode DRAM with a burst address counter. It runs on the bus clock of its controller. The controller opens a row and then issues one column command carrying a starting column. The block returns a four-word burst, which fits a cache line fill.

Only the first column comes from the controller. An internal counter steps through the other three words of the aligned group of four, wrapping inside it. Each word moves through two registers. The first stage copies the array word into an output latch. The second stage copies the latch onto the data bus. After a beat, the bus value stays driven until the next column command or until the row closes. A parameter selects one of three beat timings so the modes can be compared: 6-3-3-3, 6-2-2-2 or 5-1-1-1. A single-beat write is also supported so the array can be loaded.

Top module: `burst_dram_rd`

## Requirements
- R1: While reset is held, `dq_oe` and `beat_vld` are low.
- R2: A column command is accepted only if `row_act` was already high at the previous clock edge. A command that arrives while the row is closed, or in the same cycle the row opens, produces no beat. The row address is captured on the opening edge, and later changes on `row_addr` have no effect while the row stays open.
- R3: An accepted read gives exactly four beats. Beat k reads column `{col_addr[COL_W-1:2], (col_addr[1:0]+k) mod 4}` of the open row. A start at column 6 therefore returns columns 6, 7, 4, 5.
- R4: If `col_go` is sampled at the edge that ends bus cycle 1, beat 0 is on the bus from cycle F and beat k from cycle F+k*G. (F,G) is (6,3) for MODE 0, (6,2) for MODE 1 and (5,1) for MODE 2.
- R5: `beat_vld` is high for exactly one cycle in each cycle in which a new beat appears on `dq`, and `dq_oe` is high whenever `beat_vld` is high.
- R6: After a beat, `dq` and `dq_oe` keep their value until the next accepted column command or until the row closes.
- R7: An accepted column command turns `dq_oe` off in the following cycle.
- R8: When the edge samples `row_act` low, `dq_oe` goes low in the next cycle, and the burst in progress produces no further beats.
- R9: A column command with `wr_en` high stores `wr_data` at the open row and `col_addr`. It produces no beat, and a later read returns the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_act | input | 1 | Row open level; low closes the row and aborts a burst |
| row_addr | input | ROW_W | Row address, captured when the row opens |
| col_go | input | 1 | Column command strobe |
| wr_en | input | 1 | Makes the column command a single-beat write |
| col_addr | input | COL_W | Starting column (read) or target column (write) |
| wr_data | input | DW | Write data |
| dq | output | DW | Data bus value |
| dq_oe | output | 1 | Bus driven; low means tri-stated |
| beat_vld | output | 1 | A new beat appeared on `dq` this cycle |

## Verification
One instance of each timing mode runs in parallel on the same stimulus. When the bench sees the edge that accepts a read, it knows that edge's cycle count C. From C it computes the cycle C+F-2+k*G in which each beat first shows at the following falling edge, and it queues that cycle together with the word from its own array model. A monitor compares every `beat_vld` against the head of its mode's queue, so a beat one cycle early or late fails just as a wrong word does. Hold, turn-off and abort checks sample the falling edge right after the edge that should cause them. For an abort, only the beats due before the aborting edge are queued.

// File: rtl/burst_dram_rd.sv
module burst_dram_rd #(
  parameter int MODE  = 2,
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_act,
  input  logic [ROW_W-1:0] row_addr,
  input  logic             col_go,
  input  logic             wr_en,
  input  logic [COL_W-1:0] col_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    dq,
  output logic             dq_oe,
  output logic             beat_vld
);
  localparam int FIRST = (MODE == 2) ? 5 : 6;
  localparam int GAP   = (MODE == 0) ? 3 : (MODE == 1) ? 2 : 1;
  localparam int DEPTH = 1 << (ROW_W + COL_W);
  localparam logic [COL_W-1:0] LOW2 = COL_W'(3);

  logic [DW-1:0]    mem [DEPTH];
  logic             row_on;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] ptr;
  logic [3:0]       cd;
  logic [2:0]       left, lleft;
  logic [DW-1:0]    lat;

  wire start  = col_go & row_on & row_act;
  wire rd_go  = start & ~wr_en;
  wire wr_go  = start & wr_en;
  wire active = left != 3'd0;
  wire fire   = active & (cd == 4'd1);
  wire load   = (lleft != 3'd0) & ((cd == 4'd2) | (fire & (GAP == 1)));

  always_ff @(posedge clk) begin
    if (wr_go) mem[{row_q, col_addr}] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_on   <= 1'b0;
      row_q    <= '0;
      ptr      <= '0;
      cd       <= '0;
      left     <= '0;
      lleft    <= '0;
      lat      <= '0;
      dq       <= '0;
      dq_oe    <= 1'b0;
      beat_vld <= 1'b0;
    end else begin
      beat_vld <= 1'b0;
      if (!row_act) begin
        row_on <= 1'b0;
        left   <= '0;
        lleft  <= '0;
        dq_oe  <= 1'b0;
      end else begin
        if (!row_on) begin
          row_on <= 1'b1;
          row_q  <= row_addr;
        end
        if (start) begin
          dq_oe <= 1'b0;
          cd    <= 4'(FIRST - 2);
          left  <= rd_go ? 3'd4 : 3'd0;
          lleft <= rd_go ? 3'd4 : 3'd0;
          ptr   <= col_addr;
        end else begin
          if (active) cd <= fire ? 4'(GAP) : cd - 4'd1;
          if (load) begin
            lat   <= mem[{row_q, ptr}];
            ptr   <= (ptr & ~LOW2) | ((ptr + COL_W'(1)) & LOW2);
            lleft <= lleft - 3'd1;
          end
          if (fire) begin
            dq       <= lat;
            dq_oe    <= 1'b1;
            beat_vld <= 1'b1;
            left     <= left - 3'd1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/burst_dram_rd_chk.sv
module burst_dram_rd_chk #(
  parameter int MODE = 2,
  parameter int DW   = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          row_act,
  input logic          col_go,
  input logic          row_on,
  input logic [DW-1:0] dq,
  input logic          dq_oe,
  input logic          beat_vld
);
  localparam int FIRST = (MODE == 2) ? 5 : 6;
  localparam int GAP   = (MODE == 0) ? 3 : (MODE == 1) ? 2 : 1;

  logic [5:0] since;
  logic [2:0] nb;
  wire go = col_go & row_on & row_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since <= '0;
      nb    <= '0;
    end else if (go) begin
      since <= '0;
      nb    <= '0;
    end else begin
      if (since != 6'd63) since <= since + 6'd1;
      if (beat_vld && nb != 3'd7) nb <= nb + 3'd1;
    end
  end

  assert_closed_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !row_on |=> !dq_oe);
  assert_four_beats_R3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_vld |-> nb < 3'd4);
  assert_beat_time_R4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_vld |-> since == 6'(FIRST - 2) + 6'(nb) * 6'(GAP));
  assert_vld_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_vld |-> dq_oe);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && !beat_vld) |-> $stable(dq));
  assert_col_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !dq_oe);
  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !row_act |=> (!dq_oe && !beat_vld));
endmodule

bind burst_dram_rd burst_dram_rd_chk #(.MODE(MODE), .DW(DW)) chk (
  .clk(clk), .rst_n(rst_n), .row_act(row_act), .col_go(col_go),
  .row_on(row_on), .dq(dq), .dq_oe(dq_oe), .beat_vld(beat_vld)
);

// File: tb/burst_dram_rd_test.sv
`timescale 1ns/1ps
module burst_dram_rd_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, row_act, col_go, wr_en;
  logic [3:0] row_addr, col_addr;
  logic [7:0] wr_data;
  logic [7:0] dq_m [3];
  logic       oe_m [3];
  logic       vld_m [3];

  for (genvar m = 0; m < 3; m++) begin : g_mode
    burst_dram_rd #(.MODE(m)) uut (
      .clk(clk), .rst_n(rst_n), .row_act(row_act), .row_addr(row_addr),
      .col_go(col_go), .wr_en(wr_en), .col_addr(col_addr), .wr_data(wr_data),
      .dq(dq_m[m]), .dq_oe(oe_m[m]), .beat_vld(vld_m[m])
    );
  end

  typedef struct packed { int c; logic [7:0] d; } item_t;
  item_t      sb [3][$];
  logic [7:0] model [16][16];
  int cyc = 0, vecs = 0, errs = 0, cur_row = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int first_of(int m); return (m == 2) ? 5 : 6; endfunction
  function automatic int gap_of(int m); return (m == 0) ? 3 : (m == 1) ? 2 : 1; endfunction
  function automatic int wcol(int c, int k); return (c & 12) | ((c + k) & 3); endfunction

  task automatic check(bit ok, string req, int act, int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int m = 0; m < 3; m++) begin
        if (vld_m[m]) begin
          item_t it;
          vecs++;
          if (sb[m].size() == 0) begin
            errs++;
            $display("FAIL R2 R8 mode %0d unexpected beat: actual %0h expected none", m, dq_m[m]);
          end else begin
            it = sb[m].pop_front();
            if (it.c != cyc || it.d != dq_m[m]) begin
              errs++;
              $display("FAIL R3 R4 R5 mode %0d: actual cycle %0d data %0h expected cycle %0d data %0h",
                       m, cyc, dq_m[m], it.c, it.d);
            end
          end
        end
      end
    end
  end

  task automatic open_row(int r);
    row_act = 1'b1; row_addr = 4'(r); cur_row = r;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic write_word(int c, logic [7:0] d);
    col_go = 1'b1; wr_en = 1'b1; col_addr = 4'(c); wr_data = d;
    model[cur_row][c] = d;
    @(negedge clk);
    col_go = 1'b0; wr_en = 1'b0;
  endtask

  task automatic burst(int c, int abort_n);
    int c0;
    col_go = 1'b1; wr_en = 1'b0; col_addr = 4'(c);
    @(posedge clk); #1;
    c0 = cyc;
    for (int m = 0; m < 3; m++)
      for (int k = 0; k < 4; k++) begin
        item_t it;
        it.c = c0 + first_of(m) - 2 + k * gap_of(m);
        it.d = model[cur_row][wcol(c, k)];
        if (abort_n == 0 || it.c < c0 + abort_n) sb[m].push_back(it);
      end
    @(negedge clk);
    col_go = 1'b0;
    for (int m = 0; m < 3; m++) check(oe_m[m] == 1'b0, "R7 bus off after column", oe_m[m], 0);
    if (abort_n > 0) begin
      repeat (abort_n - 1) @(negedge clk);
      row_act = 1'b0;
    end
  endtask

  task automatic drain();
    for (int k = 0; k < 40 && (sb[0].size() + sb[1].size() + sb[2].size()) != 0; k++)
      @(negedge clk);
    @(negedge clk);
    for (int m = 0; m < 3; m++) begin
      check(sb[m].size() == 0, "R3 R4 missing beats", sb[m].size(), 0);
      sb[m].delete();
    end
  endtask

  task automatic check_hold(logic [7:0] d);
    for (int m = 0; m < 3; m++) begin
      check(oe_m[m] == 1'b1, "R6 bus held", oe_m[m], 1);
      check(dq_m[m] == d, "R6 last beat held", dq_m[m], d);
    end
  endtask

  task automatic fill_row();
    for (int c = 0; c < 16; c++) write_word(c, 8'(cur_row * 16 + c) ^ 8'hA5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; vecs++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; row_act = 1'b0; col_go = 1'b0; wr_en = 1'b0;
    row_addr = '0; col_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    for (int m = 0; m < 3; m++) begin
      check(oe_m[m] == 1'b0, "R1 reset oe", oe_m[m], 0);
      check(vld_m[m] == 1'b0, "R1 reset vld", vld_m[m], 0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    col_go = 1'b1; col_addr = 4'd0;
    @(negedge clk);
    col_go = 1'b0;
    repeat (12) @(negedge clk);
    for (int m = 0; m < 3; m++) check(oe_m[m] == 1'b0, "R2 command with row closed", oe_m[m], 0);

    row_act = 1'b1; row_addr = 4'd3; cur_row = 3; col_go = 1'b1;
    @(negedge clk);
    col_go = 1'b0;
    repeat (12) @(negedge clk);
    for (int m = 0; m < 3; m++) check(oe_m[m] == 1'b0, "R2 command on opening edge", oe_m[m], 0);

    fill_row();
    repeat (10) @(negedge clk);
    for (int m = 0; m < 3; m++) check(oe_m[m] == 1'b0, "R9 write gives no beat", oe_m[m], 0);
    row_addr = 4'd0;

    burst(0, 0); drain(); check_hold(model[3][3]);
    repeat (5) @(negedge clk); check_hold(model[3][3]);
    burst(6, 0); drain(); check_hold(model[3][5]);
    burst(13, 0); drain(); check_hold(model[3][12]);
    write_word(14, 8'h3C);
    burst(12, 0); drain(); check_hold(model[3][15]);

    row_act = 1'b0;
    @(negedge clk);
    for (int m = 0; m < 3; m++) check(oe_m[m] == 1'b0, "R8 row close drops bus", oe_m[m], 0);

    open_row(9); fill_row();
    burst(2, 0); drain(); check_hold(model[9][1]);
    burst(5, 4);
    repeat (20) @(negedge clk);
    for (int m = 0; m < 3; m++) check(oe_m[m] == 1'b0, "R8 abort tri-states", oe_m[m], 0);
    drain();

    open_row(9);
    burst(11, 0); drain(); check_hold(model[9][10]);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule